// File: doc/BRIEF.md
# Burst-Granular FIFO Full Flag with Write Reserve

This block lives in the write-clock domain of a FIFO and decides when the writer has to stop. It keeps its own write pointer and receives the read pointer from the read domain as a Gray-coded value, which it synchronises through two flops. From the two pointers it forms the occupancy and compares it in units of two words, so the flag only moves on double-word boundaries. The flag is active low.

The comparison is pipelined, so the flag asserts up to three edges after the write that fills the last nominal pair. Writes that arrive in that window are still accepted. The storage behind the block is sized at the nominal depth plus a four-word reserve, so those late words are always kept. Release needs a whole free pair below the nominal depth. The storage array and the empty-side logic are outside this block.

Top module: `burst_full_flag`

## Requirements
- R1: During and right after synchronous reset, `full_n` is 1 and `wr_ptr` is 0.
- R2: `wr_ok` is the AND of `wr_req` and the current `full_n`, in the same cycle, with no register between them.
- R3: Let occ(k) be `wr_ptr` after edge k-3 minus the read pointer sampled at edge k-4, modulo 2^PTR_W. `full_n` goes to 0 at edge k when floor(occ/2) is at least DEPTH/2. With the read pointer held, the write that brings the occupancy to DEPTH shows as `full_n` = 0 on the third edge after it.
- R4: An occupancy of DEPTH-1 neither sets nor clears the flag. `full_n` keeps its previous value.
- R5: `wr_ptr` advances by one, modulo 2^PTR_W, on every edge where `wr_ok` was 1 and holds otherwise. While `full_n` is 0, no write is accepted whatever `wr_req` does.
- R6: `full_n` returns to 1 at edge k when ceil(occ/2) is below DEPTH/2, that is when occ is DEPTH-2 or less. Starting from exactly DEPTH words, two reads are needed before the flag releases.
- R7: `rd_ptr_gray` carries the binary read pointer b encoded as b XOR (b>>1). A read-pointer change first sampled at edge F can release the flag no earlier than edge F+4.
- R8: With `wr_req` held high and no reads, starting from empty, exactly DEPTH+3 words are accepted. Occupancy never exceeds DEPTH+RESERVE. Five single reads are then needed before `full_n` returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Writer wants to store a word this cycle |
| rd_ptr_gray | input | PTR_W | Read pointer from the read domain, Gray coded |
| wr_ok | output | 1 | Write accepted this cycle |
| wr_ptr | output | PTR_W | Binary write pointer (words accepted, wrapping) |
| full_n | output | 1 | Full flag, low when full |

## Verification
An unbroken write burst from empty tells apart a correct reserve from an off-by-one in the assertion pipeline, because the number of accepted words must come out at exactly DEPTH+3. Slow single-word fills and single reads step the occupancy through DEPTH-1, DEPTH and DEPTH-2. These steps separate the floor compare used for assertion from the ceiling compare used for release, and they measure the three-edge assertion lag and the four-edge release lag. Long random runs that mix writes and reads wrap both pointers several times. This exposes Gray decoding or modulo errors that the directed cases, which stay near zero, would not reach.

// File: rtl/bff_pkg.sv
package bff_pkg;
  // Decision taken by the pair comparator for the flag register.
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_SET   = 2'd1,
    ACT_CLEAR = 2'd2
  } flag_act_e;
endpackage

// File: rtl/bff_gray_sync.sv
module bff_gray_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= gray_in;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  // Gray to binary: each bit is the XOR of all Gray bits at or above it.
  always_comb begin
    bin_out[W-1] = stg[STAGES-1][W-1];
    for (int i = W-2; i >= 0; i--) bin_out[i] = bin_out[i+1] ^ stg[STAGES-1][i];
  end
endmodule

// File: rtl/bff_wr_count.sv
module bff_wr_count #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (inc) cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/bff_pair_judge.sv
module bff_pair_judge
  import bff_pkg::*;
#(
  parameter int W     = 6,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] wr_cnt,
  input  logic [W-1:0] rd_bin,
  output logic [W-1:0] occ_q,
  output flag_act_e    act_q
);
  localparam int HALF = DEPTH / 2;

  logic [W-1:0] pairs_floor;
  logic [W-1:0] pairs_ceil;
  flag_act_e    act_d;

  always_comb begin
    pairs_floor = occ_q >> 1;
    pairs_ceil  = (occ_q + W'(1)) >> 1;
    if (pairs_floor >= W'(HALF))    act_d = ACT_SET;
    else if (pairs_ceil < W'(HALF)) act_d = ACT_CLEAR;
    else                            act_d = ACT_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q <= '0;
      act_q <= ACT_HOLD;
    end else begin
      occ_q <= wr_cnt - rd_bin;
      act_q <= act_d;
    end
  end
endmodule

// File: rtl/burst_full_flag.sv
module burst_full_flag
  import bff_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int RESERVE = 4,
  parameter int PTR_W   = $clog2(DEPTH + RESERVE) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_req,
  input  logic [PTR_W-1:0] rd_ptr_gray,
  output logic             wr_ok,
  output logic [PTR_W-1:0] wr_ptr,
  output logic             full_n
);
  localparam int SYNC_STAGES = 2;

  logic [PTR_W-1:0] rd_bin;
  logic [PTR_W-1:0] occ_words;
  flag_act_e        act;
  logic             full_n_q;

  assign wr_ok  = wr_req & full_n_q;
  assign full_n = full_n_q;

  bff_gray_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_rsync (
    .clk     (clk),
    .rst     (rst),
    .gray_in (rd_ptr_gray),
    .bin_out (rd_bin)
  );

  bff_wr_count #(.W(PTR_W)) u_wcnt (
    .clk (clk),
    .rst (rst),
    .inc (wr_ok),
    .cnt (wr_ptr)
  );

  bff_pair_judge #(.W(PTR_W), .DEPTH(DEPTH)) u_judge (
    .clk    (clk),
    .rst    (rst),
    .wr_cnt (wr_ptr),
    .rd_bin (rd_bin),
    .occ_q  (occ_words),
    .act_q  (act)
  );

  always_ff @(posedge clk) begin
    if (rst) full_n_q <= 1'b1;
    else begin
      case (act)
        ACT_SET:   full_n_q <= 1'b0;
        ACT_CLEAR: full_n_q <= 1'b1;
        default:   full_n_q <= full_n_q;
      endcase
    end
  end
endmodule

// File: rtl/bff_full_flag_chk.sv
module bff_full_flag_chk #(
  parameter int DEPTH   = 16,
  parameter int RESERVE = 4,
  parameter int PTR_W   = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             full_n,
  input logic             wr_ok,
  input logic [PTR_W-1:0] wr_ptr,
  input logic [PTR_W-1:0] occ_words
);
  localparam int CAP = DEPTH + RESERVE;

  AST_RESERVE_BOUND: assert property (@(posedge clk) disable iff (rst)
    occ_words <= PTR_W'(CAP)); // R8

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    $past(wr_ok && !rst) |-> wr_ptr == PTR_W'($past(wr_ptr) + PTR_W'(1))); // R5

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    $past(!wr_ok && !rst) |-> $stable(wr_ptr)); // R5

  AST_SET_AT_DEPTH: assert property (@(posedge clk) disable iff (rst)
    $fell(full_n) |-> $past(occ_words, 2) >= PTR_W'(DEPTH)); // R3

  AST_CLEAR_BELOW: assert property (@(posedge clk) disable iff (rst)
    $rose(full_n) |-> $past(occ_words, 2) <= PTR_W'(DEPTH - 2)); // R6

  AST_ODD_HOLDS: assert property (@(posedge clk) disable iff (rst)
    ($past(occ_words, 2) == PTR_W'(DEPTH - 1)) |-> full_n == $past(full_n)); // R4
endmodule

bind burst_full_flag bff_full_flag_chk #(
  .DEPTH(DEPTH), .RESERVE(RESERVE), .PTR_W(PTR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .full_n    (full_n),
  .wr_ok     (wr_ok),
  .wr_ptr    (wr_ptr),
  .occ_words (occ_words)
);

// File: tb/tb_burst_full_flag.sv
`timescale 1ns/1ps
module tb_burst_full_flag;
  localparam int DEPTH   = 16;
  localparam int RESERVE = 4;
  localparam int PW      = $clog2(DEPTH + RESERVE) + 1;
  localparam int M       = (1 << PW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_req = 1'b0;
  logic [PW-1:0] rd_ptr_gray = '0;
  logic          wr_ok;
  logic [PW-1:0] wr_ptr;
  logic          full_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int unsigned W = 0;
  int unsigned R = 0;
  int unsigned wq [4];
  int unsigned rq [5];
  bit exp_full = 1'b1;

  always #2 clk = ~clk;

  burst_full_flag #(.DEPTH(DEPTH), .RESERVE(RESERVE)) dut (
    .clk(clk), .rst(rst), .wr_req(wr_req), .rd_ptr_gray(rd_ptr_gray),
    .wr_ok(wr_ok), .wr_ptr(wr_ptr), .full_n(full_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit flag_next(input int unsigned occ, input bit cur);
    if ((occ >> 1) >= DEPTH/2)            return 1'b0;
    else if (((occ + 1) >> 1) < DEPTH/2)  return 1'b1;
    else                                  return cur;
  endfunction

  // One write-clock cycle with per-cycle checks against the model.
  task automatic step(input bit w, input bit r);
    bit acc;
    @(negedge clk);
    wr_req = w;
    if (r && (((W - R) & M) != 0)) R = (R + 1) & M;
    rd_ptr_gray = PW'(R ^ (R >> 1));
    #1;
    chk("R2", int'(wr_ok), int'(w && exp_full));
    chk("R3", int'(full_n), int'(exp_full));
    chk("R5", int'(wr_ptr), int'(W));
    acc = w && exp_full;
    @(posedge clk);
    W = (W + acc) & M;
    for (int i = 3; i > 0; i--) wq[i] = wq[i-1];
    for (int i = 4; i > 0; i--) rq[i] = rq[i-1];
    wq[0] = W;
    rq[0] = R;
    exp_full = flag_next((wq[3] - rq[4]) & M, exp_full);
  endtask

  initial begin
    int n;
    int lag;
    for (int i = 0; i < 4; i++) wq[i] = 0;
    for (int i = 0; i < 5; i++) rq[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", int'(full_n), 1);
    chk("R1", int'(wr_ptr), 0);
    rst = 1'b0;
    @(posedge clk);
    #1;
    chk("R1", int'(full_n), 1);
    chk("R1", int'(wr_ptr), 0);
    // The model begins at the first edge after release.
    W = 0;
    exp_full = 1'b1;

    // R8: a continuous burst from empty accepts DEPTH+3 words.
    repeat (30) step(1'b1, 1'b0);
    chk("R8", int'(W), DEPTH + 3);
    chk("R5", int'(wr_ptr), DEPTH + 3);

    // R8: single reads until release, should take five.
    n = 0;
    #1;
    while (full_n == 1'b0 && n < 10) begin
      step(1'b0, 1'b1);
      n++;
      repeat (6) step(1'b0, 1'b0);
      #1;
    end
    chk("R8", n, 5);

    // R4: one more word brings occupancy to DEPTH-1, flag stays released.
    step(1'b1, 1'b0);
    repeat (8) step(1'b0, 1'b0);
    chk("R4", int'(full_n), 1);

    // R3: the word that makes DEPTH appears on full_n three edges later.
    step(1'b1, 1'b0);
    lag = 0;
    #1;
    while (full_n == 1'b1 && lag < 10) begin
      step(1'b0, 1'b0);
      #1;
      lag++;
    end
    chk("R3", lag, 3);

    // R6: one read leaves DEPTH-1, the flag stays asserted.
    step(1'b0, 1'b1);
    repeat (8) step(1'b0, 1'b0);
    chk("R6", int'(full_n), 0);

    // R7: the second read releases four edges after it is sampled.
    step(1'b0, 1'b1);
    lag = 0;
    #1;
    while (full_n == 1'b0 && lag < 10) begin
      step(1'b0, 1'b0);
      #1;
      lag++;
    end
    chk("R7", lag, 4);

    // Random traffic, pointers wrap many times (R3 R5 R6 R7).
    for (int c = 0; c < 4000; c++) begin
      int unsigned rv = $urandom();
      if (c < 2000) step(rv[3:0] < 10, rv[7:4] < 7);
      else          step(rv[3:0] < 6,  rv[7:4] < 10);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got 0 expected 1 completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule